// File: doc/BRIEF.md
# Transmitter Power-Mode Sequencer

This block controls power for a small radio transmitter. Three control lines come in: an amplitude-modulation key, a frequency-modulation key, and an enable line that can be driven high or low or left floating. The block turns them into one of three modes: powered down, idle or powered up. In idle the control lines can be used to talk to other parts on the board while the transmitter stays dark. In the powered-up mode the amplitude key switches the power amplifier, and the frequency key sets the crystal-pulling switch.

Once powered up, the block divides the oscillator clock (its own clock input) to make a clock output for a host controller. The clock output stays low until a synchronised amplitude-good indication arrives. It is then released on a divider period boundary, so the first high phase it produces is complete. After the clock output starts, a lock-wait timer runs for a parameterised number of oscillator cycles and then raises the ready flag. The analog oscillator, the loop and the RF stage are outside the block.

Top module: `txpwr_seq`

## Requirements
- R1: Power-up: with `ctl_en_open`=1 the block powers up when `ctl_ask` or `ctl_fsk` is 1; with `ctl_en_open`=0 and `ctl_en_level`=1 it powers up whatever the keys are; `osc_en`=1 in power-up.
- R2: Power-down: with both keys 0 and the enable line low or floating, `osc_en`, `pa_en`, `fsk_sw_lowz`, `clk_out` and `ready` are all 0 (`fsk_sw_lowz`=0 means the switch is high impedance).
- R3: Idle: with `ctl_en_open`=0, `ctl_en_level`=0 and either key 1, all five outputs are 0.
- R4: In power-up, `pa_en` equals `ctl_ask`.
- R5: In power-up, `fsk_sw_lowz` is the inverse of `ctl_fsk`; outside power-up it is 0.
- R6: While running, `clk_out` has period DIV oscillator cycles, and every high phase lasts exactly DIV/2 cycles.
- R7: `clk_out` stays 0 after power-up until the amplitude-good input has passed a two-flop synchroniser. It then rises on a divider period boundary, no more than DIV+3 cycles after that input rises.
- R8: `ready` rises exactly LOCK_CYCLES cycles after the first rising edge of `clk_out` and stays high while powered up.
- R9: Leaving power-up clears `ready` and `clk_out` in the same cycle that `osc_en` falls. Re-entering power-up runs the whole clock-release and lock-wait sequence again.
- R10: Mode outputs follow the control inputs one clock later. While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_ask | input | 1 | Amplitude key; amplifier on when powered up |
| ctl_fsk | input | 1 | Frequency key; 1 opens the pulling switch |
| ctl_en_level | input | 1 | Driven level of the enable line |
| ctl_en_open | input | 1 | 1 when the enable line is floating |
| amp_ok_async | input | 1 | Oscillator amplitude good, asynchronous |
| osc_en | output | 1 | Oscillator and loop enable |
| pa_en | output | 1 | Power amplifier enable |
| fsk_sw_lowz | output | 1 | Pulling switch closed (low impedance) |
| clk_out | output | 1 | Divided clock for the host |
| ready | output | 1 | Lock wait done, transmit permitted |

## Verification
On every cycle the assertions check that nothing leaks out of the dark modes, that the amplifier follows its key only when powered up, that a driven-low enable always keeps the block dark, and that every completed clock-output high phase is exactly half a period long. Only the bench's scenarios show the end-to-end timing. It measures the delay from amplitude-good to the first clock edge, the exact lock-wait count up to `ready`, the clock period, and the full sequence running again after a power cycle through a different enable route.

// File: rtl/txpwr_pkg.sv
package txpwr_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_IDLE = 2'd1,
        PM_UP   = 2'd2
    } pmode_t;

    typedef struct packed {
        logic ask;
        logic fsk;
        logic en_level;
        logic en_open;
    } ctl_t;

    // Floating enable acts as the OR of both keys; a driven level wins.
    function automatic pmode_t decode_mode(input ctl_t c);
        logic keys;
        keys = c.ask | c.fsk;
        if (c.en_open)
            return keys ? PM_UP : PM_OFF;
        if (c.en_level)
            return PM_UP;
        return keys ? PM_IDLE : PM_OFF;
    endfunction

endpackage

// File: rtl/txpwr_mode_dec.sv
module txpwr_mode_dec
    import txpwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    output pmode_t mode_q,
    output logic   ask_q,
    output logic   fsk_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_OFF;
            ask_q  <= 1'b0;
            fsk_q  <= 1'b0;
        end else begin
            mode_q <= decode_mode(ctl);
            ask_q  <= ctl.ask;
            fsk_q  <= ctl.fsk;
        end
    end
endmodule

// File: rtl/txpwr_clk_gate.sv
module txpwr_clk_gate #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic amp_ok_async,
    output logic gate_on,
    output logic clk_out
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [1:0]    amp_sync;
    logic [CW-1:0] cnt;
    logic          gate_q;

    always_ff @(posedge clk) begin
        if (rst) amp_sync <= 2'b00;
        else     amp_sync <= {amp_sync[0], amp_ok_async};
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            gate_q <= 1'b0;
        end else begin
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
            // open the gate only as the divider wraps to phase zero
            if (amp_sync[1] && cnt == CW'(DIV - 1))
                gate_q <= 1'b1;
        end
    end

    assign gate_on = gate_q & run;
    assign clk_out = gate_on & (cnt < CW'(HALF));
endmodule

// File: rtl/txpwr_lock_timer.sv
module txpwr_lock_timer #(
    parameter int LOCK_CYCLES = 3390
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic start,
    output logic done
);
    localparam int TW = $clog2(LOCK_CYCLES + 1);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst || !run)
            tmr <= '0;
        else if (start && tmr != TW'(LOCK_CYCLES))
            tmr <= tmr + 1'b1;
    end

    assign done = run & (tmr == TW'(LOCK_CYCLES));
endmodule

// File: rtl/txpwr_seq.sv
module txpwr_seq
    import txpwr_pkg::*;
#(
    parameter int DIV         = 8,
    parameter int LOCK_CYCLES = 3390
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_ask,
    input  logic ctl_fsk,
    input  logic ctl_en_level,
    input  logic ctl_en_open,
    input  logic amp_ok_async,
    output logic osc_en,
    output logic pa_en,
    output logic fsk_sw_lowz,
    output logic clk_out,
    output logic ready
);
    ctl_t   ctl_in;
    pmode_t mode_q;
    logic   ask_q, fsk_q, up, gate_on;

    assign ctl_in = '{ask: ctl_ask, fsk: ctl_fsk, en_level: ctl_en_level, en_open: ctl_en_open};

    txpwr_mode_dec u_dec (
        .clk(clk), .rst(rst), .ctl(ctl_in),
        .mode_q(mode_q), .ask_q(ask_q), .fsk_q(fsk_q)
    );

    assign up          = (mode_q == PM_UP);
    assign osc_en      = up;
    assign pa_en       = up & ask_q;
    assign fsk_sw_lowz = up & ~fsk_q;

    txpwr_clk_gate #(.DIV(DIV)) u_gate (
        .clk(clk), .rst(rst), .run(up), .amp_ok_async(amp_ok_async),
        .gate_on(gate_on), .clk_out(clk_out)
    );

    txpwr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .run(up), .start(gate_on), .done(ready)
    );
endmodule

// File: rtl/txpwr_seq_chk.sv
module txpwr_seq_chk #(
    parameter int DIV = 8
) (
    input logic clk,
    input logic rst,
    input logic ctl_ask,
    input logic ctl_en_level,
    input logic ctl_en_open,
    input logic osc_en,
    input logic pa_en,
    input logic fsk_sw_lowz,
    input logic clk_out,
    input logic ready
);
    localparam int HALF = DIV / 2;

    int hi_run;

    always_ff @(posedge clk) begin
        if (rst)          hi_run <= 0;
        else if (clk_out) hi_run <= hi_run + 1;
        else              hi_run <= 0;
    end

    AST_DARK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!pa_en && !fsk_sw_lowz && !clk_out && !ready)); // R2

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en_open && !ctl_en_level) |=> !osc_en); // R3

    AST_PA_FOLLOWS_KEY: assert property (@(posedge clk) disable iff (rst)
        osc_en |-> (pa_en == $past(ctl_ask))); // R4

    AST_FULL_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_out) && osc_en) |-> (hi_run == HALF)); // R6

    AST_READY_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(osc_en)); // R8
endmodule

bind txpwr_seq txpwr_seq_chk #(.DIV(DIV)) u_chk (
    .clk(clk), .rst(rst), .ctl_ask(ctl_ask), .ctl_en_level(ctl_en_level),
    .ctl_en_open(ctl_en_open), .osc_en(osc_en), .pa_en(pa_en),
    .fsk_sw_lowz(fsk_sw_lowz), .clk_out(clk_out), .ready(ready)
);

// File: tb/test_txpwr_seq.sv
module test_txpwr_seq;
    localparam int DIV  = 8;
    localparam int LOCK = 20;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0, rst = 1'b1;
    logic ask = 0, fsk = 0, en_lvl = 0, en_open = 1, amp = 0;
    logic osc_en, pa_en, fsk_sw_lowz, clk_out, ready;
    int checks = 0, errors = 0;
    int cyc = 0, hi_run = 0, last_rise = -1;
    logic prev_clk = 0;

    always #5 clk = ~clk;

    txpwr_seq #(.DIV(DIV), .LOCK_CYCLES(LOCK)) i_txpwr_seq (
        .clk(clk), .rst(rst), .ctl_ask(ask), .ctl_fsk(fsk),
        .ctl_en_level(en_lvl), .ctl_en_open(en_open), .amp_ok_async(amp),
        .osc_en(osc_en), .pa_en(pa_en), .fsk_sw_lowz(fsk_sw_lowz),
        .clk_out(clk_out), .ready(ready)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic exp_up(input logic a, f, lvl, opn);
        if (opn) return a | f;
        return lvl;
    endfunction

    // pulse-width and period monitor (R6)
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (clk_out) begin
                if (!prev_clk && osc_en) begin
                    if (last_rise >= 0)
                        chk(cyc - last_rise == DIV, "R6 period", cyc - last_rise, DIV);
                    last_rise = cyc;
                end
                hi_run++;
            end else begin
                if (hi_run > 0 && osc_en)
                    chk(hi_run == HALF, "R6 high phase", hi_run, HALF);
                hi_run = 0;
            end
            if (!osc_en) last_rise = -1;
            prev_clk = clk_out;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_lock_sequence(input string tag);
        int n;
        n = 0;
        while (!clk_out && n < 40) begin
            chk(!ready, "R7 ready before clock", ready, 0);
            step();
            n++;
        end
        chk(clk_out && n <= DIV + 3, {tag, " first clock edge delay"}, n, DIV + 3);
        n = 0;
        while (!ready && n < LOCK + 20) begin
            step();
            n++;
        end
        chk(n == LOCK, {tag, " lock wait R8"}, n, LOCK);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        @(negedge clk);
        chk({osc_en, pa_en, fsk_sw_lowz, clk_out, ready} == 5'b0, "R10 reset state",
            {osc_en, pa_en, fsk_sw_lowz, clk_out, ready}, 0);
        repeat (3) step();
        rst = 0;

        // random decode sweep, amplitude-good held low (R1 R2 R3 R4 R5 R7)
        for (int i = 0; i < 48; i++) begin
            logic a, f, l, o, up;
            a = 1'($urandom); f = 1'($urandom); l = 1'($urandom); o = 1'($urandom);
            ask = a; fsk = f; en_lvl = l; en_open = o;
            step();
            up = exp_up(a, f, l, o);
            chk(osc_en == up, "R1 R2 R3 mode decode", osc_en, up);
            chk(pa_en == (up & a), "R4 amplifier key", pa_en, up & a);
            chk(fsk_sw_lowz == (up & !f), "R5 pulling switch", fsk_sw_lowz, up & !f);
            chk(!clk_out && !ready, "R7 clock held without amplitude", clk_out, 0);
        end

        // directed: idle with driven-low enable (R3)
        ask = 1; fsk = 1; en_open = 0; en_lvl = 0;
        step();
        chk({osc_en, pa_en, fsk_sw_lowz} == 3'b0, "R3 idle dark",
            {osc_en, pa_en, fsk_sw_lowz}, 0);

        // power down, then floating-enable start with frequency key (R1 R7)
        ask = 0; fsk = 0; en_open = 1;
        step();
        chk(!osc_en, "R2 power-down", osc_en, 0);
        fsk = 1;
        step();
        chk(osc_en && !pa_en && !fsk_sw_lowz, "R1 floating enable start", osc_en, 1);
        for (int i = 0; i < 30; i++) begin
            chk(!clk_out, "R7 clock low before amplitude", clk_out, 0);
            step();
        end
        amp = 1;
        step();
        chk(!clk_out, "R7 synchroniser delay", clk_out, 0);
        run_lock_sequence("R7");
        repeat (5) begin
            step();
            chk(ready, "R8 ready holds", ready, 1);
        end

        // amplitude modulation and frequency keying (R4 R5)
        ask = 1;
        step();
        chk(pa_en, "R4 amplifier on", pa_en, 1);
        fsk = 0;
        step();
        chk(fsk_sw_lowz && osc_en, "R5 switch closed", fsk_sw_lowz, 1);
        fsk = 1;
        step();
        chk(!fsk_sw_lowz, "R5 switch open", fsk_sw_lowz, 0);
        ask = 0;
        step();
        chk(!pa_en, "R4 amplifier off", pa_en, 0);

        // drop to power-down mid-period (R9)
        repeat (3) step();
        fsk = 0;
        step();
        chk(!osc_en && !ready && !clk_out, "R9 same-cycle shutdown",
            {osc_en, ready, clk_out}, 0);

        // restart through a driven-high enable with keys low (R1 R9)
        en_open = 0; en_lvl = 1;
        step();
        chk(osc_en && fsk_sw_lowz && !clk_out && !ready, "R9 restart clean",
            {osc_en, fsk_sw_lowz, clk_out, ready}, 4'b1100);
        run_lock_sequence("R9");

        // idle from powered state (R3 R9)
        en_lvl = 0; fsk = 1;
        step();
        chk(!osc_en && !clk_out && !ready, "R3 idle from power-up",
            {osc_en, clk_out, ready}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule